// File: doc/BRIEF.md
# Pel Write Address and Merge Unit

This block accepts one pel write at a time and carries it out against a bit-planar, banked display memory. A request brings signed drawing coordinates, a pel format, a colour value, a destination bank, a mask plane number and a mask enable. The block folds the coordinates into a cyclic 13-bit drawing space. It drops any pel that falls outside the 2048 by 2048 memory space. For the others it forms the word address and the bit index inside each plane byte.

Every memory access is a read-modify-write. The word holding the pel is read. In each plane byte the one addressed bit is replaced by the matching colour bit, and the word is written back. Short pels touch one bank. Long pels spread over banks 0 and 1. When the format carries a mask bit and the mask enable is set, a read of bank 3 comes first and decides whether the colour is written at all. The memory side is a plain synchronous 32-bit port. Read data comes back one clock after the request.

Top module: `pel_write_unit`

## Requirements
- R1: The coordinates are taken modulo 8192. Only bits 12..0 of each 16-bit input count, so inputs that differ by a multiple of 8192 address the same pel.
- R2: If either wrapped coordinate is 2048 or more, the block makes no memory request and raises done in the clock right after acceptance.
- R3: The memory word address is Y[10:0] followed by X[10:3], with Y in the upper 11 bits of the 19-bit address.
- R4: Plane p sits in word bits 8p+7..8p. A write changes only bit 8p+X[2:0] of each plane, for p = 0..3, and leaves the other 28 bits as read.
- R5: Format code 0 (short) puts colour bit p into plane p of the requested bank. It uses one 8-clock memory cycle: the read comes in its first clock and the write-back with the same bank and address in its fifth clock. Done comes 9 clocks after acceptance.
- R6: Format code 2 (long) writes colour bits 3..0 to bank 0 and then colour bits 7..4 to bank 1, in two memory cycles. The requested bank has no effect. Done comes 17 clocks after acceptance.
- R7: With format code 1 or 3 and the mask enable set, the block first spends one memory cycle reading bank 3. Bit 8m+X[2:0] of that word, where m is the requested mask plane, gates the write. A 1 lets the colour cycles of the format follow. A 0 ends the request with no write, and done comes 9 clocks after acceptance.
- R8: With the mask enable clear, format codes 1 and 3 behave exactly like codes 0 and 2. The mask enable has no effect on codes 0 and 2.
- R9: After reset, and between requests, the block is ready, done is low and no memory request is made. It accepts nothing while a request is in progress. Done stays high until the done handshake is taken, and ready returns in the following clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken on this clock |
| req_x | input | 16 | Drawing X, two's complement |
| req_y | input | 16 | Drawing Y, two's complement |
| req_fmt | input | 2 | Pel format: 0 short, 1 short masked, 2 long, 3 long masked |
| req_color | input | 8 | Colour value |
| req_bank | input | 2 | Destination bank for short pels |
| req_mask_plane | input | 2 | Plane of bank 3 holding the mask |
| req_mask_en | input | 1 | Destination mask use |
| done_valid | output | 1 | Request finished |
| done_ready | input | 1 | Completion taken |
| mem_req | output | 1 | Memory access this clock |
| mem_we | output | 1 | 1 write, 0 read |
| mem_bank | output | 2 | Bank of the access |
| mem_addr | output | 19 | Word address |
| mem_wdata | output | 32 | Merged write word |
| mem_rdata | input | 32 | Read word, valid the clock after a read |

## Verification
The hardest case to reach is a masked write whose outcome depends on earlier traffic. The gating bit lives in bank 3 at the same address, so the bench must first place a known mask value there. Directed steps do this with short pels written into bank 3: an all-zero colour clears the pel's bit in every plane and an all-ones colour sets it. Masked requests that follow then exercise both the blocked and the permitted path. Random traffic is confined to a small coordinate window so that masked, long and short writes keep colliding on shared words. This exposes any disturbance of neighbouring bits or banks.

// File: rtl/pel_pkg.sv
// Package: shared encodings for the pel write unit.
// Assumes four banks of four planes; format bit 1 selects long pels,
// format bit 0 selects a masked pel.
package pel_pkg;
    typedef enum logic [1:0] {
        FMT_SHORT   = 2'd0,
        FMT_SHORT_M = 2'd1,
        FMT_LONG    = 2'd2,
        FMT_LONG_M  = 2'd3
    } pel_fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_MASK = 3'd1,
        ST_COL0 = 3'd2,
        ST_COL1 = 3'd3,
        ST_DONE = 3'd4
    } seq_st_e;

    localparam logic [1:0] MASK_BANK = 2'd3;
    localparam logic [1:0] LONG_LO_BANK = 2'd0;
    localparam logic [1:0] LONG_HI_BANK = 2'd1;
endpackage

// File: rtl/pel_addr_map.sv
// Module: wraps raw coordinates into the cyclic drawing space, flags pels
// outside the memory space and splits X into word part and bit index.
// Assumes COORD_W > DRAW_W > SPACE_W > BSEL_W.
module pel_addr_map #(
    parameter int COORD_W = 16,
    parameter int DRAW_W  = 13,
    parameter int SPACE_W = 11,
    parameter int BSEL_W  = 3,
    parameter int ADDR_W  = 2*SPACE_W - BSEL_W
) (
    input  logic [COORD_W-1:0] x_in,
    input  logic [COORD_W-1:0] y_in,
    output logic               clip,
    output logic [ADDR_W-1:0]  word_addr,
    output logic [BSEL_W-1:0]  bit_sel
);
    logic [DRAW_W-1:0] xw;
    logic [DRAW_W-1:0] yw;
    logic              unused_hi;

    // Modulo wrap: keep the low drawing bits only.
    assign xw = x_in[DRAW_W-1:0];
    assign yw = y_in[DRAW_W-1:0];
    assign unused_hi = ^{x_in[COORD_W-1:DRAW_W], y_in[COORD_W-1:DRAW_W]};

    // Outside the memory space when any bit above the space width is set.
    assign clip = (|xw[DRAW_W-1:SPACE_W]) || (|yw[DRAW_W-1:SPACE_W]);

    // Word address: Y above the byte part of X.
    assign word_addr = {yw[SPACE_W-1:0], xw[SPACE_W-1:BSEL_W]};
    assign bit_sel   = xw[BSEL_W-1:0];
endmodule

// File: rtl/pel_merge.sv
// Module: replaces one bit in every plane byte of a memory word.
// Assumes plane p occupies bits p*BYTE_W and up.
module pel_merge #(
    parameter int NPLANE = 4,
    parameter int BYTE_W = 8,
    parameter int BSEL_W = 3
) (
    input  logic [NPLANE*BYTE_W-1:0] old_word,
    input  logic [NPLANE-1:0]        pel_bits,
    input  logic [BSEL_W-1:0]        bit_sel,
    output logic [NPLANE*BYTE_W-1:0] new_word
);
    for (genvar p = 0; p < NPLANE; p++) begin : g_plane
        logic [BYTE_W-1:0] merged;
        // Overwrite the selected bit of this plane byte.
        always_comb begin
            merged = old_word[p*BYTE_W +: BYTE_W];
            merged[bit_sel] = pel_bits[p];
        end
        assign new_word[p*BYTE_W +: BYTE_W] = merged;
    end
endmodule

// File: rtl/pel_seq.sv
// Module: request sequencer. Steps through mask, low and high colour
// memory cycles of CYC_LEN clocks each, or straight to done on a clip.
// Assumes the decision inputs are stable during the last phase of a cycle.
module pel_seq
    import pel_pkg::*;
#(
    parameter int CYC_LEN = 8,
    parameter int PH_W    = $clog2(CYC_LEN)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic            clip,
    input  logic            start_mask,
    input  logic            is_long,
    input  logic            mask_ok,
    input  logic            done_ready,
    output seq_st_e         state,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(CYC_LEN - 1);

    // State and phase register with the cycle-end transitions.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            phase <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    phase <= '0;
                    if (accept) begin
                        if (clip)            state <= ST_DONE;
                        else if (start_mask) state <= ST_MASK;
                        else                 state <= ST_COL0;
                    end
                end
                ST_MASK, ST_COL0, ST_COL1: begin
                    if (phase == PH_LAST) begin
                        phase <= '0;
                        if (state == ST_MASK)      state <= mask_ok ? ST_COL0 : ST_DONE;
                        else if (state == ST_COL0) state <= is_long ? ST_COL1 : ST_DONE;
                        else                       state <= ST_DONE;
                    end else begin
                        phase <= phase + 1'b1;
                    end
                end
                ST_DONE: if (done_ready) state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pel_write_unit.sv
// Module: top of the pel write unit. Takes one request, registers its
// address fields, and drives read-modify-write cycles on the memory port.
// Assumes memory read data arrives the clock after a read request and
// holds until the next read.
module pel_write_unit
    import pel_pkg::*;
#(
    parameter int COORD_W = 16,
    parameter int DRAW_W  = 13,
    parameter int SPACE_W = 11,
    parameter int NPLANE  = 4,
    parameter int BYTE_W  = 8,
    parameter int CYC_LEN = 8,
    localparam int BSEL_W = $clog2(BYTE_W),
    localparam int ADDR_W = 2*SPACE_W - BSEL_W,
    localparam int WORD_W = NPLANE*BYTE_W,
    localparam int PLN_W  = $clog2(NPLANE)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic [COORD_W-1:0] req_x,
    input  logic [COORD_W-1:0] req_y,
    input  logic [1:0]         req_fmt,
    input  logic [2*NPLANE-1:0] req_color,
    input  logic [1:0]         req_bank,
    input  logic [PLN_W-1:0]   req_mask_plane,
    input  logic               req_mask_en,
    output logic               done_valid,
    input  logic               done_ready,
    output logic               mem_req,
    output logic               mem_we,
    output logic [1:0]         mem_bank,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic [WORD_W-1:0]  mem_wdata,
    input  logic [WORD_W-1:0]  mem_rdata
);
    localparam int PH_W = $clog2(CYC_LEN);
    localparam logic [PH_W-1:0] PH_RD = PH_W'(1);
    localparam logic [PH_W-1:0] PH_WR = PH_W'(CYC_LEN / 2);

    seq_st_e             state;
    logic [PH_W-1:0]     phase;
    logic                accept, in_clip, busy, mask_ok;
    logic [ADDR_W-1:0]   in_addr, r_addr;
    logic [BSEL_W-1:0]   in_bsel, r_bsel;
    logic                r_long;
    logic [2*NPLANE-1:0] r_color;
    logic [1:0]          r_bank;
    logic [PLN_W-1:0]    r_mp;
    logic [WORD_W-1:0]   rd_q;
    logic [NPLANE-1:0]   nibble;

    assign accept     = req_valid && req_ready;
    assign req_ready  = (state == ST_IDLE);
    assign done_valid = (state == ST_DONE);
    assign busy       = (state == ST_MASK) || (state == ST_COL0) || (state == ST_COL1);

    pel_addr_map #(
        .COORD_W(COORD_W), .DRAW_W(DRAW_W), .SPACE_W(SPACE_W),
        .BSEL_W(BSEL_W), .ADDR_W(ADDR_W)
    ) u_map (
        .x_in(req_x), .y_in(req_y), .clip(in_clip),
        .word_addr(in_addr), .bit_sel(in_bsel)
    );

    // Capture the request fields on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_addr  <= '0;
            r_bsel  <= '0;
            r_long  <= 1'b0;
            r_color <= '0;
            r_bank  <= '0;
            r_mp    <= '0;
        end else if (accept) begin
            r_addr  <= in_addr;
            r_bsel  <= in_bsel;
            r_long  <= req_fmt[1];
            r_color <= req_color;
            r_bank  <= req_bank;
            r_mp    <= req_mask_plane;
        end
    end

    // Hold the word returned by the read of the current memory cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)                      rd_q <= '0;
        else if (busy && phase == PH_RD) rd_q <= mem_rdata;
    end

    assign mask_ok = rd_q[int'(r_mp)*BYTE_W + int'(r_bsel)];

    pel_seq #(.CYC_LEN(CYC_LEN), .PH_W(PH_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .accept(accept), .clip(in_clip),
        .start_mask(req_fmt[0] && req_mask_en), .is_long(r_long),
        .mask_ok(mask_ok), .done_ready(done_ready),
        .state(state), .phase(phase)
    );

    // Memory port: read in phase 0, write-back in the middle phase.
    always_comb begin
        mem_req = busy && ((phase == '0) || (phase == PH_WR && state != ST_MASK));
        mem_we  = busy && (phase == PH_WR) && (state != ST_MASK);
        if (state == ST_MASK)      mem_bank = MASK_BANK;
        else if (state == ST_COL1) mem_bank = LONG_HI_BANK;
        else if (r_long)           mem_bank = LONG_LO_BANK;
        else                       mem_bank = r_bank;
        nibble = (state == ST_COL1) ? r_color[2*NPLANE-1:NPLANE] : r_color[NPLANE-1:0];
    end
    assign mem_addr = r_addr;

    pel_merge #(.NPLANE(NPLANE), .BYTE_W(BYTE_W), .BSEL_W(BSEL_W)) u_merge (
        .old_word(rd_q), .pel_bits(nibble), .bit_sel(r_bsel), .new_word(mem_wdata)
    );
endmodule

// File: rtl/pel_write_unit_chk.sv
// Module: assertion checker for the pel write unit, bound to the top.
// Assumes memory read data holds from the clock after a read until the
// next read.
module pel_write_unit_chk #(
    parameter int COORD_W = 16,
    parameter int DRAW_W  = 13,
    parameter int SPACE_W = 11,
    parameter int ADDR_W  = 19,
    parameter int WORD_W  = 32,
    parameter int NPLANE  = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_valid,
    input logic               req_ready,
    input logic [COORD_W-1:0] req_x,
    input logic [COORD_W-1:0] req_y,
    input logic               done_valid,
    input logic               done_ready,
    input logic               mem_req,
    input logic               mem_we,
    input logic [1:0]         mem_bank,
    input logic [ADDR_W-1:0]  mem_addr,
    input logic [WORD_W-1:0]  mem_wdata,
    input logic [WORD_W-1:0]  mem_rdata
);
    logic port_clip;
    assign port_clip = (|req_x[DRAW_W-1:SPACE_W]) || (|req_y[DRAW_W-1:SPACE_W]);

    AST_CLIP_DONE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && port_clip) |=> (done_valid && !mem_req)); // R2
    AST_WB_MATCHES_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($past(mem_req, 4) && !$past(mem_we, 4)
            && $past(mem_addr, 4) == mem_addr && $past(mem_bank, 4) == mem_bank)); // R5
    AST_FEW_BITS_CHANGED: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> ($countones(mem_wdata ^ $past(mem_rdata, 3)) <= NPLANE)); // R4
    AST_NO_MEM_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !req_ready); // R9
    AST_DONE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !done_ready) |=> done_valid); // R9
    AST_READY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && done_valid)); // R9
endmodule

bind pel_write_unit pel_write_unit_chk #(
    .COORD_W(COORD_W), .DRAW_W(DRAW_W), .SPACE_W(SPACE_W),
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .NPLANE(NPLANE)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_x(req_x), .req_y(req_y), .done_valid(done_valid), .done_ready(done_ready),
    .mem_req(mem_req), .mem_we(mem_we), .mem_bank(mem_bank), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
);

// File: tb/pel_write_unit_bench.sv
// Bench: seeded random and directed pel writes against a memory model,
// compared with a shadow memory computed from the requirements.
module pel_write_unit_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [15:0] req_x = '0, req_y = '0;
    logic [1:0]  req_fmt = '0, req_bank = '0, req_mask_plane = '0;
    logic [7:0]  req_color = '0;
    logic        req_mask_en = 1'b0;
    logic        done_valid, done_ready = 1'b0;
    logic        mem_req, mem_we;
    logic [1:0]  mem_bank;
    logic [18:0] mem_addr;
    logic [31:0] mem_wdata, mem_rdata = '0;

    int n_cmp = 0, n_bad = 0, wr_cnt = 0, rd_cnt = 0;
    logic [31:0] mem_m [int];
    logic [31:0] shadow [int];

    always #(CLK_PERIOD/2) clk = ~clk;

    pel_write_unit u_pel_write_unit (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_x(req_x), .req_y(req_y), .req_fmt(req_fmt), .req_color(req_color),
        .req_bank(req_bank), .req_mask_plane(req_mask_plane), .req_mask_en(req_mask_en),
        .done_valid(done_valid), .done_ready(done_ready),
        .mem_req(mem_req), .mem_we(mem_we), .mem_bank(mem_bank), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] init_word(int key);
        logic [31:0] k = key;
        return (k * 32'h9E3779B1) ^ 32'hC3A5_5A3C;
    endfunction

    function automatic logic [31:0] mem_get(int key);
        return mem_m.exists(key) ? mem_m[key] : init_word(key);
    endfunction

    function automatic logic [31:0] sh_get(int key);
        return shadow.exists(key) ? shadow[key] : init_word(key);
    endfunction

    // Synchronous memory model: read data one clock after the request.
    always @(posedge clk) begin
        if (mem_req) begin
            if (mem_we) begin
                mem_m[{11'd0, mem_bank, mem_addr}] = mem_wdata;
                wr_cnt++;
            end else begin
                mem_rdata <= mem_get({11'd0, mem_bank, mem_addr});
                rd_cnt++;
            end
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic shadow_put(input int key, input logic [2:0] b, input logic [3:0] nb);
        logic [31:0] w = sh_get(key);
        for (int p = 0; p < 4; p++) w[8*p + int'(b)] = nb[p];
        shadow[key] = w;
    endtask

    task automatic do_req(input string lbl, input logic [15:0] x, input logic [15:0] y,
                          input logic [1:0] fmt, input logic [7:0] col, input logic [1:0] bk,
                          input logic [1:0] mp, input logic men);
        logic [12:0] xw = x[12:0], yw = y[12:0];
        bit clipped = (xw[12:11] != 0) || (yw[12:11] != 0);
        logic [18:0] addr = {yw[10:0], xw[10:3]};
        logic [2:0] b = xw[2:0];
        bit domask = fmt[0] && men;
        bit permit;
        int exp_wr, exp_rd, exp_lat, w0, r0, n;
        string tg;
        permit = domask ? sh_get({11'd0, 2'd3, addr})[8*int'(mp) + int'(b)] : 1'b1;
        exp_wr = (clipped || !permit) ? 0 : (fmt[1] ? 2 : 1);
        exp_rd = clipped ? 0 : (int'(domask) + exp_wr);
        exp_lat = clipped ? 1 : 1 + 8*(int'(domask) + exp_wr);
        tg = clipped ? "R2" : domask ? "R7" : fmt[1] ? "R6" : "R5";
        if (!clipped && permit) begin
            if (fmt[1]) begin
                shadow_put({11'd0, 2'd0, addr}, b, col[3:0]);
                shadow_put({11'd0, 2'd1, addr}, b, col[7:4]);
            end else begin
                shadow_put({11'd0, bk, addr}, b, col[3:0]);
            end
        end
        w0 = wr_cnt; r0 = rd_cnt;
        check(req_ready == 1'b1, {lbl, " R9 ready before request"}, req_ready, 1);
        req_x = x; req_y = y; req_fmt = fmt; req_color = col;
        req_bank = bk; req_mask_plane = mp; req_mask_en = men; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!done_valid && n < 60) begin
            @(negedge clk);
            n++;
        end
        check(n == exp_lat, {lbl, " ", tg, " latency"}, n, exp_lat);
        check(wr_cnt - w0 == exp_wr, {lbl, " ", tg, " write count"}, wr_cnt - w0, exp_wr);
        check(rd_cnt - r0 == exp_rd, {lbl, domask ? " R7" : " R8", " read count"},
              rd_cnt - r0, exp_rd);
        for (int bb = 0; bb < 4; bb++) begin
            int key = {11'd0, 2'(bb), addr};
            check(mem_get(key) == sh_get(key), {lbl, " R3 R4 word contents"},
                  mem_get(key), sh_get(key));
        end
        @(negedge clk);
        check(done_valid && !req_ready, {lbl, " R9 done held"}, {done_valid, req_ready}, 2'b10);
        done_ready = 1'b1;
        @(negedge clk);
        done_ready = 1'b0;
        check(!done_valid && req_ready, {lbl, " R9 back to idle"}, {done_valid, req_ready}, 2'b01);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (180000) @(posedge clk);
        n_bad++;
        $display("FAIL R9 watchdog: actual hung expected finished");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd5150));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !done_valid && !mem_req, "R9 reset state",
              {req_ready, done_valid, mem_req}, 3'b100);

        // Directed corners.
        do_req("clip x=2048", 16'd2048, 16'd5, 2'd0, 8'h0F, 2'd2, 2'd0, 1'b0);
        do_req("clip x=-1", 16'hFFFF, 16'd5, 2'd2, 8'hFF, 2'd0, 2'd0, 1'b0);
        do_req("clip y=6000", 16'd9, 16'd6000, 2'd1, 8'hA5, 2'd1, 2'd2, 1'b1);
        do_req("R1 wrap neg", 16'(-8187), 16'd3, 2'd0, 8'h05, 2'd2, 2'd0, 1'b0);
        do_req("R1 wrap pos", 16'd10239, 16'(16384 + 2047), 2'd0, 8'h0A, 2'd1, 2'd0, 1'b0);
        do_req("R6 long bank ignored", 16'd13, 16'd7, 2'd2, 8'h5A, 2'd3, 2'd0, 1'b0);
        do_req("R5 bank3 clear", 16'd21, 16'd4, 2'd0, 8'h00, 2'd3, 2'd0, 1'b0);
        do_req("R7 mask denies", 16'd21, 16'd4, 2'd1, 8'h0F, 2'd0, 2'd2, 1'b1);
        do_req("R7 long mask denies", 16'd21, 16'd4, 2'd3, 8'hFF, 2'd0, 2'd1, 1'b1);
        do_req("R8 mask off", 16'd21, 16'd4, 2'd1, 8'h09, 2'd0, 2'd2, 1'b0);
        do_req("R5 bank3 set", 16'd21, 16'd4, 2'd0, 8'h0F, 2'd3, 2'd0, 1'b0);
        do_req("R7 mask permits", 16'd21, 16'd4, 2'd1, 8'h06, 2'd2, 2'd3, 1'b1);
        do_req("R7 long mask permits", 16'd21, 16'd4, 2'd3, 8'hC3, 2'd2, 2'd0, 1'b1);
        do_req("R8 unmasked fmt mask_en", 16'd22, 16'd4, 2'd2, 8'h3C, 2'd1, 2'd0, 1'b1);

        // Seeded random traffic in a small window to force collisions.
        for (int i = 0; i < 300; i++) begin
            logic [15:0] rx, ry;
            if ($urandom % 10 == 0) begin
                rx = 16'($urandom); ry = 16'($urandom);
            end else begin
                rx = 16'(int'($urandom % 32) + 8192*(int'($urandom % 5) - 2));
                ry = 16'(int'($urandom % 4) + 8192*(int'($urandom % 3) - 1));
            end
            do_req("random", rx, ry, 2'($urandom), 8'($urandom), 2'($urandom),
                   2'($urandom), 1'($urandom));
        end
        summary();
        $finish;
    end
endmodule